// File: doc/BRIEF.md
# Sector Error Bit Corrector

This block takes the error positions produced by a BCH error-locator stage for one 512-byte sector and repairs the sector in place. Each position is a bit index into the whole codeword, which holds the parity nibbles and then the data bits. The block drops positions that land in the parity part. For a position in the data part, it turns the position into a byte address and a one-hot bit mask inside the sector buffer, with the bit order reversed. It then flips that bit by reading the byte and writing it back.

Positions can be loaded in two ways: all slots at once from a flat vector, or one at a time through a push port that fills the slots in order. A start strobe carries the number of positions to use and the parity nibble count. The block walks the slots in order, makes one buffer read and one buffer write for each correction, and signals the end with a one-cycle done pulse. Syndrome computation and locator solving are handled outside this block.

Top module: `ecc_loc_corrector`

## Requirements
- R1: After reset, `done`, `busy`, `bad_loc`, `buf_rd_en` and `buf_wr_en` are all low.
- R2: A position below 4 × `nibbles` lies in the parity region. It causes no buffer access and does not raise `bad_loc`.
- R3: For a data position, let off = position − 4 × `nibbles`. The corrected byte sits at address (4096 − off − 1) / 8, using integer division.
- R4: The byte written back equals the byte read XOR a one-hot mask with its single set bit at position off mod 8 (bit 0 is the LSB).
- R5: Each correction puts `buf_rd_en` high for one cycle. Read data is taken on the next cycle, which has `buf_wr_en` high and the same address. Read and write are never high together.
- R6: Slots are handled in index order, from slot 0 up to the error count. Slots beyond the count are never used.
- R7: A start with an error count of zero causes no buffer access, and `done` goes high in the cycle after the start.
- R8: A data position with off ≥ 4096 gives a one-cycle `bad_loc` pulse and causes no buffer access.
- R9: `loc_load` writes every slot from `loc_flat`, with slot i at bits [13i+12:13i]. Each `loc_push` writes the next slot, starting at slot 0 after reset, after `loc_load`, or after `done`.
- R10: `done` is a one-cycle pulse after the last slot. A start while `busy` is high is ignored.
- R11: An error count above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a correction pass |
| err_count | input | 4 | Number of positions to apply |
| nibbles | input | 6 | Parity nibble count of the code |
| loc_load | input | 1 | Parallel load of all slots |
| loc_flat | input | 104 | Positions for parallel load, slot 0 in the low bits |
| loc_push | input | 1 | Serial load of the next slot |
| loc_data | input | 13 | Position for serial load |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rdata | input | 8 | Buffer read data, valid the cycle after the read |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished (pulse) |
| bad_loc | output | 1 | Position beyond the sector (pulse) |

## Verification
The bench walks every position from 0 up past the end of the sector for a 26-nibble code, and covers the boundaries for 13-nibble and 52-nibble codes. This catches an off-by-one at the parity edge: such a design would flip a byte for position 103, or skip position 104. It also catches a missing bit reversal, which would write near byte 0 instead of byte 511, and a mask taken from the wrong end of the byte. Further runs load slots serially, then check write order, count clamping, a zero count, and a start pulse during a busy pass. A design that reorders slots, reads past the count, or restarts mid-pass would log the wrong sequence of writes or an extra done.

// File: rtl/ecc_fix_pkg.sv
// Package: shared state encoding for the sector error bit corrector.
// Assumes: one pass at a time; no other types are shared.
package ecc_fix_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_EVAL = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_DONE = 3'd4
    } fix_state_t;
endpackage

// File: rtl/ecc_loc_decode.sv
// Module: maps one codeword bit position to a byte address and bit mask.
// Assumes: parity nibbles come first in the codeword; data bits are numbered
// in reverse, so data offset 0 lands in the last byte of the sector.
module ecc_loc_decode #(
    parameter int LOC_W        = 13,
    parameter int NIB_W        = 6,
    parameter int SECTOR_BYTES = 512,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int SECTOR_BITS = SECTOR_BYTES * 8
) (
    input  logic [LOC_W-1:0]  loc,
    input  logic [NIB_W-1:0]  nibbles,
    output logic              in_parity,
    output logic              out_of_range,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        bit_mask
);
    logic [LOC_W:0] parity_bits;
    logic [LOC_W:0] offset;

    // Parity size in bits, and the data offset behind it.
    always_comb begin
        parity_bits  = (LOC_W+1)'(nibbles) << 2;
        in_parity    = ({1'b0, loc} < parity_bits);
        offset       = {1'b0, loc} - parity_bits;
        out_of_range = !in_parity && (offset >= (LOC_W+1)'(SECTOR_BITS));
        byte_addr    = ADDR_W'(SECTOR_BYTES - 1) - offset[ADDR_W+2:3];
        bit_mask     = 8'd1 << offset[2:0];
    end
endmodule

// File: rtl/ecc_loc_store.sv
// Module: slot registers for error positions, filled in parallel or serially.
// Assumes: pushes beyond the last slot are dropped; parallel load wins over push.
module ecc_loc_store #(
    parameter int MAX_ERR = 8,
    parameter int LOC_W   = 13,
    localparam int IDX_W  = $clog2(MAX_ERR + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     par_load,
    input  logic [MAX_ERR*LOC_W-1:0] par_locs,
    input  logic                     push,
    input  logic [LOC_W-1:0]         push_data,
    input  logic                     ptr_clr,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [LOC_W-1:0]         loc_out
);
    logic [LOC_W-1:0] slot_q [MAX_ERR];
    logic [IDX_W-1:0] wr_ptr;

    // Serial write pointer: restarts on reset, parallel load or pass end.
    always_ff @(posedge clk) begin
        if (!rst_n || par_load || ptr_clr)
            wr_ptr <= '0;
        else if (push && wr_ptr < IDX_W'(MAX_ERR))
            wr_ptr <= wr_ptr + 1'b1;
    end

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
        // One slot: parallel load or serial fill.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (par_load)
                slot_q[g] <= par_locs[g*LOC_W +: LOC_W];
            else if (push && wr_ptr == IDX_W'(g))
                slot_q[g] <= push_data;
        end
    end

    // Read mux for the slot in process.
    always_comb begin
        loc_out = '0;
        for (int i = 0; i < MAX_ERR; i++)
            if (rd_idx == IDX_W'(i)) loc_out = slot_q[i];
    end
endmodule

// File: rtl/ecc_loc_corrector.sv
// Module: walks the error slots in order and flips each data-region bit in
// the sector buffer by read-modify-write.
// Assumes: buffer read data is valid one cycle after buf_rd_en.
module ecc_loc_corrector #(
    parameter int MAX_ERR      = 8,
    parameter int LOC_W        = 13,
    parameter int NIB_W        = 6,
    parameter int SECTOR_BYTES = 512,
    localparam int IDX_W       = $clog2(MAX_ERR + 1),
    localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [IDX_W-1:0]         err_count,
    input  logic [NIB_W-1:0]         nibbles,
    input  logic                     loc_load,
    input  logic [MAX_ERR*LOC_W-1:0] loc_flat,
    input  logic                     loc_push,
    input  logic [LOC_W-1:0]         loc_data,
    output logic [ADDR_W-1:0]        buf_addr,
    output logic                     buf_rd_en,
    input  logic [7:0]               buf_rdata,
    output logic                     buf_wr_en,
    output logic [7:0]               buf_wdata,
    output logic                     busy,
    output logic                     done,
    output logic                     bad_loc
);
    import ecc_fix_pkg::*;

    fix_state_t        state;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [NIB_W-1:0]  nib_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        mask_q;
    logic              bad_q;
    logic [LOC_W-1:0]  cur_loc;
    logic              dec_parity, dec_oor;
    logic [ADDR_W-1:0] dec_addr;
    logic [7:0]        dec_mask;

    ecc_loc_store #(.MAX_ERR(MAX_ERR), .LOC_W(LOC_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .par_load(loc_load), .par_locs(loc_flat),
        .push(loc_push), .push_data(loc_data),
        .ptr_clr(done), .rd_idx(idx_q), .loc_out(cur_loc)
    );

    ecc_loc_decode #(.LOC_W(LOC_W), .NIB_W(NIB_W), .SECTOR_BYTES(SECTOR_BYTES)) dec_i (
        .loc(cur_loc), .nibbles(nib_q),
        .in_parity(dec_parity), .out_of_range(dec_oor),
        .byte_addr(dec_addr), .bit_mask(dec_mask)
    );

    // Pass sequencer: one slot per evaluation, read then write per correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            cnt_q  <= '0;
            nib_q  <= '0;
            addr_q <= '0;
            mask_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            bad_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    idx_q <= '0;
                    nib_q <= nibbles;
                    cnt_q <= (err_count > IDX_W'(MAX_ERR)) ? IDX_W'(MAX_ERR) : err_count;
                    state <= (err_count == '0) ? ST_DONE : ST_EVAL;
                end
                ST_EVAL: begin
                    if (idx_q == cnt_q) begin
                        state <= ST_DONE;
                    end else if (dec_parity || dec_oor) begin
                        bad_q <= dec_oor;
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        addr_q <= dec_addr;
                        mask_q <= dec_mask;
                        state  <= ST_RD;
                    end
                end
                ST_RD:   state <= ST_WR;
                ST_WR: begin
                    idx_q <= idx_q + 1'b1;
                    state <= ST_EVAL;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the sequencer state.
    always_comb begin
        buf_addr  = addr_q;
        buf_rd_en = (state == ST_RD);
        buf_wr_en = (state == ST_WR);
        buf_wdata = buf_rdata ^ mask_q;
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        bad_loc   = bad_q;
    end

    // R5: a write always follows a read of the same byte.
    a_r5_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($past(buf_rd_en) && buf_addr == $past(buf_addr)));
    // R5: read and write strobes are exclusive.
    a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));
    // R10: done lasts exactly one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: zero count finishes in the next cycle.
    a_r7_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && err_count == '0) |=> (done && !buf_rd_en));
    // R2: a parity-region slot never causes a read.
    a_r2_parity_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL && idx_q != cnt_q && dec_parity) |=> (!buf_rd_en && !bad_loc));
    // R8: out-of-range pulse is never next to a buffer access.
    a_r8_bad_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bad_loc |-> !buf_wr_en && !buf_rd_en);
endmodule

// File: tb/ecc_loc_corrector_tb_top.sv
module ecc_loc_corrector_tb_top;
    localparam int LW = 13;

    logic clk = 0, rst_n = 0;
    logic start = 0, loc_load = 0, loc_push = 0;
    logic [3:0] err_count = 0;
    logic [5:0] nibbles = 26;
    logic [8*LW-1:0] loc_flat = '0;
    logic [LW-1:0] loc_data = '0;
    logic [8:0] buf_addr;
    logic buf_rd_en, buf_wr_en, busy, done, bad_loc;
    logic [7:0] buf_rdata, buf_wdata;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];
    int wr_cnt = 0, bad_cnt = 0, done_cnt = 0;
    int wlog [16];

    always #5 clk = ~clk;

    ecc_loc_corrector dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
        .nibbles(nibbles), .loc_load(loc_load), .loc_flat(loc_flat),
        .loc_push(loc_push), .loc_data(loc_data), .buf_addr(buf_addr),
        .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en),
        .buf_wdata(buf_wdata), .busy(busy), .done(done), .bad_loc(bad_loc)
    );

    // Sector buffer model and access log.
    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= mem[buf_addr];
        if (buf_wr_en) begin
            mem[buf_addr] <= buf_wdata;
            if (wr_cnt < 16) wlog[wr_cnt] = int'(buf_addr);
            wr_cnt = wr_cnt + 1;
        end
        if (bad_loc) bad_cnt = bad_cnt + 1;
        if (done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected effect of one position on the shadow buffer; returns 0 parity, 1 fix, 2 bad.
    function automatic int model(input int loc, input int nib);
        int pb, off;
        pb = 4 * nib;
        if (loc < pb) return 0;
        off = loc - pb;
        if (off >= 4096) return 2;
        exp_mem[(4096 - off - 1) / 8] ^= 8'(1 << (off % 8));
        return 1;
    endfunction

    task automatic run(input int cnt, input int nib, input bit poke);
        wr_cnt = 0; bad_cnt = 0; done_cnt = 0;
        @(negedge clk);
        err_count = 4'(cnt); nibbles = 6'(nib); start = 1;
        @(negedge clk);
        start = 0;
        if (poke) begin
            @(negedge clk); start = 1; err_count = 4'd1;
            @(negedge clk); start = 0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_par(input int l [8]);
        @(negedge clk);
        for (int i = 0; i < 8; i++) loc_flat[i*LW +: LW] = LW'(l[i]);
        loc_load = 1;
        @(negedge clk);
        loc_load = 0;
    endtask

    function automatic bit mem_ok();
        for (int a = 0; a < 512; a++) if (mem[a] !== exp_mem[a]) return 0;
        return 1;
    endfunction

    initial begin
        #1_900_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int l [8];
        int r, ew, eb;
        for (int a = 0; a < 512; a++) begin
            mem[a] = 8'(a * 37 + 11);
            exp_mem[a] = mem[a];
        end
        repeat (3) @(negedge clk);
        chk(!done && !busy && !bad_loc && !buf_rd_en && !buf_wr_en, "R1", int'(busy), 0);
        rst_n = 1;
        @(negedge clk);

        // Sweep every position for a 26-nibble code (R2 R3 R4 R8).
        for (int loc = 0; loc < 4096 + 104 + 12; loc++) begin
            for (int i = 0; i < 8; i++) l[i] = 8191;
            l[0] = loc;
            load_par(l);
            r = model(loc, 26);
            run(1, 26, 0);
            ew = (r == 1) ? 1 : 0;
            eb = (r == 2) ? 1 : 0;
            if (r == 0) chk(wr_cnt == 0 && bad_cnt == 0, "R2", wr_cnt, 0);
            else if (r == 2) chk(wr_cnt == 0 && bad_cnt == 1, "R8", bad_cnt, 1);
            else begin
                chk(wr_cnt == 1 && wlog[0] == (4096 - (loc - 104) - 1) / 8, "R3", wlog[0], (4096 - (loc - 104) - 1) / 8);
                chk(mem[wlog[0]] == exp_mem[wlog[0]], "R4", int'(mem[wlog[0]]), int'(exp_mem[wlog[0]]));
            end
            chk(wr_cnt == ew && bad_cnt == eb && done_cnt == 1, "R10", done_cnt, 1);
        end
        chk(mem_ok(), "R4", 0, 1);

        // Boundaries for 13- and 52-nibble codes (R2 R3).
        foreach (l[i]) l[i] = 0;
        l[0] = 51; l[1] = 52; l[2] = 52 + 4095; l[3] = 52 + 4096;
        load_par(l);
        for (int i = 0; i < 4; i++) void'(model(l[i], 13));
        run(4, 13, 0);
        chk(wr_cnt == 2 && wlog[0] == 511 && wlog[1] == 0, "R3", wr_cnt, 2);
        chk(bad_cnt == 1, "R8", bad_cnt, 1);
        l[0] = 207; l[1] = 208; l[2] = 215; l[3] = 216;
        load_par(l);
        for (int i = 0; i < 4; i++) void'(model(l[i], 52));
        run(4, 52, 0);
        chk(wr_cnt == 3 && wlog[0] == 511 && wlog[1] == 511 && wlog[2] == 510, "R2", wr_cnt, 3);
        chk(mem_ok(), "R4", 0, 1);

        // Order and clamping (R6 R11).
        for (int i = 0; i < 8; i++) l[i] = 104 + 8 * (i * 5 + 3) + i;
        load_par(l);
        for (int i = 0; i < 8; i++) void'(model(l[i], 26));
        run(12, 26, 0);
        chk(wr_cnt == 8, "R11", wr_cnt, 8);
        for (int i = 0; i < 8; i++)
            chk(wlog[i] == 511 - (i * 5 + 3), "R6", wlog[i], 511 - (i * 5 + 3));
        chk(mem_ok(), "R4", 0, 1);
        load_par(l);
        for (int i = 0; i < 3; i++) void'(model(l[i], 26));
        run(3, 26, 0);
        chk(wr_cnt == 3 && wlog[2] == 511 - 13, "R6", wr_cnt, 3);

        // Zero count (R7).
        run(0, 26, 0);
        chk(wr_cnt == 0 && done_cnt == 1, "R7", wr_cnt, 0);

        // Serial load (R9) with a start pulse mid-pass (R10).
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); loc_push = 1; loc_data = LW'(104 + 8 * (100 + i));
        end
        @(negedge clk); loc_push = 0;
        for (int i = 0; i < 3; i++) void'(model(104 + 8 * (100 + i), 26));
        run(3, 26, 1);
        chk(wr_cnt == 3 && wlog[0] == 411 && wlog[2] == 409, "R9", wlog[0], 411);
        chk(done_cnt == 1, "R10", done_cnt, 1);
        chk(mem_ok(), "R9", 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule